// File: doc/BRIEF.md
# Raster Timing Generator for a 20 MHz Pixel Clock

This block sequences the raster of a 640x480-class display at roughly 60 frames per second when the only pixel clock on hand is 20 MHz rather than the customary 25.175 MHz. Because the clock is slower, the horizontal and vertical totals are retuned. Each scan line lasts 636 clock periods and 503 of them carry picture. Each frame has 528 lines and 480 of them are visible. The block drives the horizontal and vertical pixel coordinates, one sync pulse per axis, a combined blanking signal, and a flag that is high only during vertical blanking.

Each axis is a counter paired with a four-state phase machine: active, front porch, sync, back porch. The horizontal axis advances on every clock. The vertical axis advances only on the clock where the horizontal count wraps. Downstream colour and sprite logic uses the coordinates to fetch pixels and the blanking signal to force black. A slow bus master can poll the vertical-blanking flag to find a safe window for updating position registers. All porch and sync lengths are parameters, and the defaults give the timing described here.

Top module: `vga20_timing`

## Requirements
- R1: A synchronous active-high reset forces pix_x and pix_y to 0 and holds hsync, vsync, blank and vblank low. On the first clock edge after reset is released, pix_x becomes 1.
- R2: pix_x increases by one on every clock from 0 to 635, then returns to 0 on the next clock.
- R3: pix_y holds its value except on the clock where pix_x goes from 635 to 0. On that clock pix_y increases by one, and it goes from 527 back to 0.
- R4: hsync is high, active-high, exactly while pix_x is in 577..595. That is 19 clocks, starting 74 clocks after the last visible pixel 502 and ending 40 clocks before pixel 0 of the next line.
- R5: vsync is high, active-high, exactly while pix_y is in 494..495. That is two lines, after 14 lines of blanking below line 479 and followed by 32 lines of blanking.
- R6: blank is high exactly when pix_x is 503 or more, or when pix_y is 480 or more.
- R7: vblank is high exactly when pix_y is 480 or more, whatever the value of pix_x.
- R8: A frame is 636 x 528 clocks long, so successive rising edges of vsync are exactly that many clocks apart. With a shortened vertical parameter set, the spacing is 636 times the vertical total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, 20 MHz in the target mode |
| rst | input | 1 | Synchronous reset, active high |
| pix_x | output | XW (10) | Horizontal pixel position, 0..635 |
| pix_y | output | YW (10) | Line number, 0..527 |
| hsync | output | 1 | Horizontal sync, high during the pulse |
| vsync | output | 1 | Vertical sync, high during the pulse |
| blank | output | 1 | High outside the visible 503x480 area |
| vblank | output | 1 | High during the vertical blanking lines |

## Verification
The coordinates and the phase states sit in registers that share the same clock edge. The sync and blanking outputs are decoded from the phase states alone, so every output reflects the clock edge that produced the current coordinates, with no extra latency. Reset takes effect at the first rising edge while it is high, and counting resumes at the first rising edge after it is released. The bench keeps its own coordinate model, which it also advances on the rising edge, and compares every output with that model at the following falling edge. Each check therefore looks at a settled value one half-period after the edge that caused it. Pulse widths, the start position of hsync and the frame spacing are measured by counting those falling-edge samples.

// File: rtl/vga20_pkg.sv
package vga20_pkg;

    // Default geometry for a 20 MHz pixel clock
    localparam int DEF_H_ACTIVE = 503;
    localparam int DEF_H_FRONT  = 74;
    localparam int DEF_H_SYNC   = 19;
    localparam int DEF_H_BACK   = 40;
    localparam int DEF_V_ACTIVE = 480;
    localparam int DEF_V_FRONT  = 14;
    localparam int DEF_V_SYNC   = 2;
    localparam int DEF_V_BACK   = 32;

    // Phase of one scan axis
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;

    // Decoded per-axis control flags
    typedef struct packed {
        logic sync;
        logic blank;
    } axis_flags_t;

    function automatic axis_flags_t phase_flags(input phase_e ph);
        axis_flags_t f;
        f.sync  = (ph == PH_SYNC);
        f.blank = (ph != PH_ACTIVE);
        return f;
    endfunction

endpackage

// File: rtl/tg_axis.sv
module tg_axis
    import vga20_pkg::*;
#(
    parameter int ACTIVE = DEF_H_ACTIVE,
    parameter int FRONT  = DEF_H_FRONT,
    parameter int SYNC   = DEF_H_SYNC,
    parameter int BACK   = DEF_H_BACK,
    localparam int TOTAL = ACTIVE + FRONT + SYNC + BACK,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output axis_flags_t   flags
);

    // Count values after which the next phase begins
    localparam logic [CW-1:0] C_LAST     = CW'(TOTAL - 1);
    localparam logic [CW-1:0] C_TO_BACK  = CW'(ACTIVE + FRONT + SYNC - 1);
    localparam logic [CW-1:0] C_TO_SYNC  = CW'(ACTIVE + FRONT - 1);
    localparam logic [CW-1:0] C_TO_FRONT = CW'(ACTIVE - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    phase_e        ph_q, ph_d;

    always_comb begin
        cnt_d = cnt_q;
        ph_d  = ph_q;
        if (adv) begin
            cnt_d = (cnt_q == C_LAST) ? '0 : cnt_q + CW'(1);
            // Later boundaries are tested first so that a zero-length
            // porch skips straight to the following phase.
            if (cnt_q == C_LAST)
                ph_d = PH_ACTIVE;
            else if (cnt_q == C_TO_BACK)
                ph_d = PH_BACK;
            else if (cnt_q == C_TO_SYNC)
                ph_d = PH_SYNC;
            else if (cnt_q == C_TO_FRONT)
                ph_d = PH_FRONT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= PH_ACTIVE;
        end else begin
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
        end
    end

    assign cnt   = cnt_q;
    assign flags = phase_flags(ph_q);

endmodule

// File: rtl/tg_merge.sv
module tg_merge
    import vga20_pkg::*;
(
    input  axis_flags_t hf,
    input  axis_flags_t vf,
    output logic        hsync,
    output logic        vsync,
    output logic        blank,
    output logic        vblank
);

    assign hsync  = hf.sync;
    assign vsync  = vf.sync;
    assign blank  = hf.blank | vf.blank;
    assign vblank = vf.blank;

endmodule

// File: rtl/vga20_timing.sv
module vga20_timing
    import vga20_pkg::*;
#(
    parameter int H_ACTIVE = DEF_H_ACTIVE,
    parameter int H_FRONT  = DEF_H_FRONT,
    parameter int H_SYNC   = DEF_H_SYNC,
    parameter int H_BACK   = DEF_H_BACK,
    parameter int V_ACTIVE = DEF_V_ACTIVE,
    parameter int V_FRONT  = DEF_V_FRONT,
    parameter int V_SYNC   = DEF_V_SYNC,
    parameter int V_BACK   = DEF_V_BACK,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int XW      = $clog2(H_TOTAL),
    localparam int YW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          vblank
);

    axis_flags_t hf, vf;
    logic        line_end;

    tg_axis #(
        .ACTIVE (H_ACTIVE),
        .FRONT  (H_FRONT),
        .SYNC   (H_SYNC),
        .BACK   (H_BACK)
    ) i_haxis (
        .clk   (clk),
        .rst   (rst),
        .adv   (1'b1),
        .cnt   (pix_x),
        .flags (hf)
    );

    // The line counter steps on the last pixel clock of each line
    assign line_end = (pix_x == XW'(H_TOTAL - 1));

    tg_axis #(
        .ACTIVE (V_ACTIVE),
        .FRONT  (V_FRONT),
        .SYNC   (V_SYNC),
        .BACK   (V_BACK)
    ) i_vaxis (
        .clk   (clk),
        .rst   (rst),
        .adv   (line_end),
        .cnt   (pix_y),
        .flags (vf)
    );

    tg_merge i_merge (
        .hf     (hf),
        .vf     (vf),
        .hsync  (hsync),
        .vsync  (vsync),
        .blank  (blank),
        .vblank (vblank)
    );

endmodule

// File: rtl/vga20_timing_chk.sv
module vga20_timing_chk #(
    parameter int H_ACTIVE = 503,
    parameter int H_FRONT  = 74,
    parameter int H_SYNC   = 19,
    parameter int H_BACK   = 40,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 14,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 32,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int XW      = $clog2(H_TOTAL),
    localparam int YW      = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y,
    input logic          hsync,
    input logic          vsync,
    input logic          blank,
    input logic          vblank
);

    localparam int HS_BEG = H_ACTIVE + H_FRONT;
    localparam int HS_END = HS_BEG + H_SYNC;
    localparam int VS_BEG = V_ACTIVE + V_FRONT;
    localparam int VS_END = VS_BEG + V_SYNC;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pix_x == '0 && pix_y == '0 && !hsync && !vsync && !blank && !vblank));

    p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_x) < H_TOTAL - 1) |=> (int'(pix_x) == int'($past(pix_x)) + 1));

    p_x_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_x) == H_TOTAL - 1) |=> (pix_x == '0));

    p_y_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_x) != H_TOTAL - 1) |=> $stable(pix_y));

    p_y_step_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_x) == H_TOTAL - 1 && int'(pix_y) < V_TOTAL - 1)
        |=> (int'(pix_y) == int'($past(pix_y)) + 1));

    p_y_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_x) == H_TOTAL - 1 && int'(pix_y) == V_TOTAL - 1) |=> (pix_y == '0));

    p_hsync_window_r4: assert property (@(posedge clk) disable iff (rst)
        hsync == (int'(pix_x) >= HS_BEG && int'(pix_x) < HS_END));

    p_vsync_window_r5: assert property (@(posedge clk) disable iff (rst)
        vsync == (int'(pix_y) >= VS_BEG && int'(pix_y) < VS_END));

    p_blank_area_r6: assert property (@(posedge clk) disable iff (rst)
        blank == (int'(pix_x) >= H_ACTIVE || int'(pix_y) >= V_ACTIVE));

    p_vblank_rows_r7: assert property (@(posedge clk) disable iff (rst)
        vblank == (int'(pix_y) >= V_ACTIVE));

    // R8: vsync can only start at the first pixel of a line
    p_vsync_line_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (pix_x == '0));

endmodule

bind vga20_timing vga20_timing_chk #(
    .H_ACTIVE (H_ACTIVE),
    .H_FRONT  (H_FRONT),
    .H_SYNC   (H_SYNC),
    .H_BACK   (H_BACK),
    .V_ACTIVE (V_ACTIVE),
    .V_FRONT  (V_FRONT),
    .V_SYNC   (V_SYNC),
    .V_BACK   (V_BACK)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .pix_x  (pix_x),
    .pix_y  (pix_y),
    .hsync  (hsync),
    .vsync  (vsync),
    .blank  (blank),
    .vblank (vblank)
);

// File: tb/test_vga20_timing.sv
module test_vga20_timing;

    // Default geometry, taken from the requirements
    localparam int HA = 503, HF = 74, HS = 19, HB = 40;
    localparam int HT = HA + HF + HS + HB;
    localparam int VA = 480, VF = 14, VS = 2, VB = 32;
    localparam int VT = VA + VF + VS + VB;
    // Shortened vertical geometry for the frame-level instance
    localparam int SA = 6, SF = 2, SS = 2, SB = 3;
    localparam int ST = SA + SF + SS + SB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [9:0] dx, dy;
    logic       dhs, dvs, dbl, dvb;
    logic [9:0] sx;
    logic [3:0] sy;
    logic       shs, svs, sbl, svb;

    vga20_timing i_vga20_timing (
        .clk (clk), .rst (rst), .pix_x (dx), .pix_y (dy),
        .hsync (dhs), .vsync (dvs), .blank (dbl), .vblank (dvb)
    );

    vga20_timing #(
        .V_ACTIVE (SA), .V_FRONT (SF), .V_SYNC (SS), .V_BACK (SB)
    ) i_vga20_timing_short (
        .clk (clk), .rst (rst), .pix_x (sx), .pix_y (sy),
        .hsync (shs), .vsync (svs), .blank (sbl), .vblank (svb)
    );

    // Reference coordinates, stepped on the same edge as the design
    int mx = 0, my = 0, nx = 0, ny = 0;
    always @(posedge clk) begin
        if (rst) begin
            mx <= 0; my <= 0; nx <= 0; ny <= 0;
        end else begin
            mx <= (mx == HT - 1) ? 0 : mx + 1;
            if (mx == HT - 1) my <= (my == VT - 1) ? 0 : my + 1;
            nx <= (nx == HT - 1) ? 0 : nx + 1;
            if (nx == HT - 1) ny <= (ny == ST - 1) ? 0 : ny + 1;
        end
    end

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int e_hs(input int x);
        return int'(x >= HA + HF && x < HA + HF + HS);
    endfunction

    function automatic int e_blank(input int x, input int y, input int act);
        return int'(x >= HA || y >= act);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            failures++;
            $display("FAIL watchdog R1..all got %0d exp completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R1 pix_x", int'(dx), 0);
        chk("R1 pix_y", int'(dy), 0);
        chk("R1 hsync", int'(dhs), 0);
        chk("R1 vsync", int'(dvs), 0);
        chk("R1 blank", int'(dbl), 0);
        chk("R1 vblank", int'(dvb), 0);
        chk("R1 short pix_y", int'(sy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pix_x after release", int'(dx), 1);
    endtask

    task automatic t_line_scan();
        int run = 0;
        int prev = 0;
        for (int i = 0; i < 3 * HT + 20; i++) begin
            @(negedge clk);
            chk("R2 pix_x", int'(dx), mx);
            chk("R3 pix_y", int'(dy), my);
            chk("R4 hsync", int'(dhs), e_hs(mx));
            chk("R5 vsync", int'(dvs), 0);
            chk("R6 blank", int'(dbl), e_blank(mx, my, VA));
            chk("R7 vblank", int'(dvb), int'(my >= VA));
            if (dhs && prev == 0) chk("R4 hsync start", int'(dx), HA + HF);
            if (dhs) run++;
            else if (prev != 0) begin
                chk("R4 hsync width", run, HS);
                run = 0;
            end
            prev = int'(dhs);
        end
    endtask

    task automatic t_frame_scan();
        int last_rise = -1;
        int prev = int'(svs);
        int prev_y = int'(sy);
        int wraps = 0;
        int rises = 0;
        for (int i = 0; i < 2 * ST * HT + 40; i++) begin
            @(negedge clk);
            chk("R2 short pix_x", int'(sx), nx);
            chk("R3 short pix_y", int'(sy), ny);
            chk("R5 vsync", int'(svs), int'(ny >= SA + SF && ny < SA + SF + SS));
            chk("R6 blank", int'(sbl), e_blank(nx, ny, SA));
            chk("R7 vblank", int'(svb), int'(ny >= SA));
            if (prev_y == ST - 1 && sy == 4'd0) wraps++;
            if (svs && prev == 0) begin
                rises++;
                chk("R5 vsync start line", int'(sy), SA + SF);
                if (last_rise >= 0) chk("R8 frame period", i - last_rise, ST * HT);
                last_rise = i;
            end
            prev = int'(svs);
            prev_y = int'(sy);
        end
        chk("R3 frame wrap seen", int'(wraps > 0), 1);
        chk("R8 vsync pulses seen", int'(rises >= 2), 1);
    endtask

    task automatic t_mid_reset();
        repeat (137) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid pix_x", int'(dx), 0);
        chk("R1 mid pix_y", int'(dy), 0);
        chk("R1 mid blank", int'(dbl), 0);
        chk("R1 mid short pix_y", int'(sy), 0);
        chk("R1 mid short vblank", int'(svb), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid pix_x resumes", int'(dx), 1);
    endtask

    initial begin
        t_reset_state();
        t_line_scan();
        t_frame_scan();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule